// File: doc/BRIEF.md
# Page-Splitting Flash Program Sequencer

This block takes one program request, given as a start address and a byte count, and turns it into a series of page-program operations for a serial NOR flash engine. No operation crosses a page boundary. The page size is a parameter and is 256 bytes by default. Each chunk is the smaller of two values: the room left in the current page, or the bytes still to write. So an unaligned request becomes a partial first page, then whole pages, then a partial last page. Each chunk's address is the previous chunk's address plus the previous chunk's length.

For every chunk the sequencer issues three kinds of command in turn:
- a write-enable command;
- a page-program command, during which payload bytes flow from the input stream to the engine;
- one-byte status reads, repeated until the write-in-progress bit reads clear.

When the last chunk has finished, the block pulses a request-complete strobe and a buffered-read invalidate strobe.

The payload uses valid/ready streams. Toward the engine, `fl_valid` is asserted only while a program command is active and fewer than the chunk's length bytes have moved in that command. The input stream sees the engine's back-pressure directly: `in_ready` equals `fl_ready` while the gate is open and is low otherwise. No byte is held inside the block. The command side is plain. `cmd_start` is a one-cycle strobe, and the engine answers with a one-cycle `cmd_done`. That strobe carries `cmd_status` for status reads.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `cache_inval`, `cmd_start`, `fl_valid` and `in_ready` are all 0.
- R2: Each program command's address and length follow from the request. The length is min(PAGE_BYTES − addr mod PAGE_BYTES, bytes remaining). The next chunk starts at the previous address plus the previous length. A program never crosses a page boundary.
- R3: Per chunk, commands come in a fixed order, with these `cmd_op` codes, lengths and addresses:
  - write-enable: `cmd_op`=1, length 0, the chunk address;
  - program: `cmd_op`=2, the chunk length, the chunk address;
  - status read: `cmd_op`=3, length 1, address 0. It is repeated while `cmd_status` bit 0 returns 1, and only bit 0 is examined.
- R4: Payload bytes pass from `in_data` to `fl_data` unchanged and in order. Exactly the chunk length moves per program command. `in_ready` and `fl_valid` are 0 outside a program command.
- R5: The request ends when a status read returns bit 0 clear with no bytes remaining. On the next cycle, `done` and `cache_inval` pulse together for one cycle, with `busy` low.
- R6: A zero-length request issues no command. It raises `done` in the cycle after acceptance, with `cache_inval` low.
- R7: `req_start` while `busy` is high is ignored. The command stream of the running request is unchanged.
- R8: A `req_start` in the cycle `done` is high is accepted.
- R9: `cmd_start` lasts one cycle. No new command starts before the engine's `cmd_done` for the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Request strobe, taken when idle |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Byte count |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion strobe |
| cache_inval | output | 1 | One-cycle buffered-read invalidate |
| cmd_start | output | 1 | Command strobe to engine |
| cmd_op | output | 2 | 1 write-enable, 2 program, 3 status read |
| cmd_addr | output | ADDR_W | Command address |
| cmd_len | output | PG_W+1 | Command data length in bytes |
| cmd_done | input | 1 | Engine completion strobe |
| cmd_status | input | 8 | Status byte, valid with `cmd_done` of a status read |
| in_valid | input | 1 | Payload input valid |
| in_ready | output | 1 | Payload input ready |
| in_data | input | DATA_W | Payload input byte |
| fl_valid | output | 1 | Payload to engine valid |
| fl_ready | input | 1 | Engine accepts payload |
| fl_data | output | DATA_W | Payload byte to engine |

## Verification
The end-of-request strobes can fall in the same cycle as the acceptance of the next request. The bench provokes this by raising `req_start` while `done` is high. It judges the result by whether the second request's command stream starts correctly and completes. A second coincidence is a payload byte moving in the same cycle the program command is strobed. The engine model counts that byte as part of the chunk while stalling the byte stream in a fixed pattern. Offsets and lengths are swept over a 16-byte page, so the first, middle and last chunks each see every alignment.

// File: rtl/fps_pkg.sv
package fps_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_WREN = 2'd1,
    OP_PROG = 2'd2,
    OP_RDSR = 2'd3
  } fps_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WREN_GO,
    ST_WREN_WAIT,
    ST_PROG_GO,
    ST_PROG_WAIT,
    ST_POLL_GO,
    ST_POLL_WAIT
  } fps_state_e;
endpackage

// File: rtl/fps_chunk_calc.sv
module fps_chunk_calc #(
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 256,
  localparam int PG_W      = $clog2(PAGE_BYTES),
  localparam int CLEN_W    = PG_W + 1
) (
  input  logic [PG_W-1:0]   offset,
  input  logic [LEN_W-1:0]  remaining,
  output logic [CLEN_W-1:0] chunk
);
  logic [CLEN_W-1:0] room;

  always_comb begin
    room = CLEN_W'(PAGE_BYTES) - {1'b0, offset};
    if (remaining < LEN_W'(room)) chunk = remaining[CLEN_W-1:0];
    else                          chunk = room;
  end
endmodule

// File: rtl/fps_byte_gate.sv
module fps_byte_gate #(
  parameter int DATA_W = 8,
  parameter int CLEN_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open,
  input  logic [CLEN_W-1:0] limit,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              fl_valid,
  input  logic              fl_ready,
  output logic [DATA_W-1:0] fl_data
);
  logic [CLEN_W-1:0] cnt_q;
  logic              pass;

  assign pass     = open && (cnt_q < limit);
  assign fl_valid = in_valid && pass;
  assign in_ready = fl_ready && pass;
  assign fl_data  = in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (!open)               cnt_q <= '0;
    else if (fl_valid && fl_ready) cnt_q <= cnt_q + 1'b1;
  end

  // R4
  gate_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open |-> cnt_q <= limit);

  // R4
  gate_closed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !open |-> !fl_valid && !in_ready);
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import fps_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 256,
  parameter int DATA_W     = 8,
  localparam int PG_W      = $clog2(PAGE_BYTES),
  localparam int CLEN_W    = PG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              busy,
  output logic              done,
  output logic              cache_inval,
  output logic              cmd_start,
  output logic [1:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [CLEN_W-1:0] cmd_len,
  input  logic              cmd_done,
  input  logic [7:0]        cmd_status,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              fl_valid,
  input  logic              fl_ready,
  output logic [DATA_W-1:0] fl_data
);
  fps_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic              done_q, inval_q;
  logic [CLEN_W-1:0] chunk;
  logic              prog_open;
  fps_op_e           op_w;

  fps_chunk_calc #(.LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)) u_calc (
    .offset    (addr_q[PG_W-1:0]),
    .remaining (rem_q),
    .chunk     (chunk)
  );

  assign prog_open = (state_q == ST_PROG_GO) || (state_q == ST_PROG_WAIT);

  fps_byte_gate #(.DATA_W(DATA_W), .CLEN_W(CLEN_W)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .open     (prog_open),
    .limit    (chunk),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .fl_valid (fl_valid),
    .fl_ready (fl_ready),
    .fl_data  (fl_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      done_q  <= 1'b0;
      inval_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      inval_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_start) begin
          if (req_len == '0) begin
            done_q <= 1'b1;
          end else begin
            addr_q  <= req_addr;
            rem_q   <= req_len;
            state_q <= ST_WREN_GO;
          end
        end
        ST_WREN_GO:   state_q <= ST_WREN_WAIT;
        ST_WREN_WAIT: if (cmd_done) state_q <= ST_PROG_GO;
        ST_PROG_GO:   state_q <= ST_PROG_WAIT;
        ST_PROG_WAIT: if (cmd_done) begin
          addr_q  <= addr_q + ADDR_W'(chunk);
          rem_q   <= rem_q - LEN_W'(chunk);
          state_q <= ST_POLL_GO;
        end
        ST_POLL_GO:   state_q <= ST_POLL_WAIT;
        ST_POLL_WAIT: if (cmd_done) begin
          if (cmd_status[0]) begin
            state_q <= ST_POLL_GO;
          end else if (rem_q == '0) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            inval_q <= 1'b1;
          end else begin
            state_q <= ST_WREN_GO;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_WREN_GO, ST_WREN_WAIT: op_w = OP_WREN;
      ST_PROG_GO, ST_PROG_WAIT: op_w = OP_PROG;
      ST_POLL_GO, ST_POLL_WAIT: op_w = OP_RDSR;
      default:                  op_w = OP_NONE;
    endcase
  end

  assign cmd_op      = op_w;
  assign cmd_start   = (state_q == ST_WREN_GO) || (state_q == ST_PROG_GO) ||
                       (state_q == ST_POLL_GO);
  assign cmd_addr    = (op_w == OP_RDSR) ? '0 : addr_q;
  assign cmd_len     = (op_w == OP_PROG) ? chunk :
                       (op_w == OP_RDSR) ? CLEN_W'(1) : '0;
  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign cache_inval = inval_q;

  logic [CLEN_W:0] prog_end;
  assign prog_end = {2'b00, cmd_addr[PG_W-1:0]} + {1'b0, cmd_len};

  // R9
  cmd_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !cmd_start);

  // R2
  no_page_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && cmd_op == 2'd2) |-> (cmd_len != '0) && (prog_end <= (CLEN_W+1)'(PAGE_BYTES)));

  // R3
  prog_after_wren_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && cmd_op == 2'd2) |-> $past(state_q) == ST_WREN_WAIT);

  // R3
  status_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && state_q == ST_POLL_WAIT) |-> !$isunknown(cmd_status));

  // R5
  inval_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cache_inval |-> done && !busy);
endmodule

// File: tb/flash_prog_seq_bench.sv
module flash_prog_seq_bench;
  localparam int AW = 16, LW = 8, PB = 16, DW = 8, CW = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, req_start, busy, done, cache_inval, cmd_start, cmd_done;
  logic [AW-1:0] req_addr, cmd_addr;
  logic [LW-1:0] req_len;
  logic [1:0] cmd_op;
  logic [CW-1:0] cmd_len;
  logic [7:0] cmd_status;
  logic in_valid, in_ready, fl_valid, fl_ready;
  logic [DW-1:0] in_data, fl_data;

  flash_prog_seq #(.ADDR_W(AW), .LEN_W(LW), .PAGE_BYTES(PB), .DATA_W(DW)) u_flash_prog_seq (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_addr(req_addr), .req_len(req_len),
    .busy(busy), .done(done), .cache_inval(cache_inval), .cmd_start(cmd_start), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_done(cmd_done), .cmd_status(cmd_status),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .fl_valid(fl_valid), .fl_ready(fl_ready), .fl_data(fl_data));

  int checks = 0, fails = 0;
  int exp_a[64], exp_l[64];
  int n_chunks = 0, ck = 0, ph = 0, polls_left = 0, poll_seed = 0;
  int src_idx = 0, cyc = 0;
  bit eng_busy = 0;
  int eng_op = 0, eng_len = 0, got = 0, tmr = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // engine model and payload source
  initial begin
    cmd_done = 0; cmd_status = 0; fl_ready = 0; in_valid = 0; in_data = 0;
    wait (rst_n === 1'b1);
    forever begin
      @(negedge clk);
      cyc++;
      cmd_done = eng_busy && tmr == 0 && (eng_op != 2 || got == eng_len);
      if (eng_busy && tmr > 0) tmr--;
      cmd_status = (eng_op == 3 && polls_left > 0) ? 8'h03 : 8'h82;
      fl_ready = (cyc % 3) != 0;
      in_valid = (cyc % 5) != 1;
      in_data  = src_idx[7:0];
      #1;
      if (cmd_done) begin
        eng_busy = 0;
        if (eng_op == 3) begin
          if (polls_left > 0) polls_left--;
          else begin ck++; ph = 0; end
        end
      end
      if (cmd_start) begin
        chk(!eng_busy, "R9 command before done", 1, 0);
        if (ck >= n_chunks) chk(0, "R3 unexpected command", int'(cmd_op), 0);
        else if (ph == 0) begin
          chk(cmd_op == 2'd1 && cmd_len == 0 && int'(cmd_addr) == exp_a[ck],
              "R3 write-enable", int'(cmd_addr), exp_a[ck]);
          ph = 1;
        end else if (ph == 1) begin
          chk(cmd_op == 2'd2, "R3 program op", int'(cmd_op), 2);
          chk(int'(cmd_addr) == exp_a[ck], "R2 chunk address", int'(cmd_addr), exp_a[ck]);
          chk(int'(cmd_len) == exp_l[ck], "R2 chunk length", int'(cmd_len), exp_l[ck]);
          ph = 2;
          polls_left = (poll_seed + ck) % 3;
        end else begin
          chk(cmd_op == 2'd3 && cmd_len == 1 && cmd_addr == 0, "R3 status read",
              int'(cmd_op), 3);
        end
        eng_busy = 1; eng_op = int'(cmd_op); eng_len = int'(cmd_len); got = 0;
        tmr = (cmd_op == 2'd2) ? 0 : 1;
      end
      if ((fl_valid && fl_ready) != (in_valid && in_ready))
        chk(0, "R4 handshake mismatch", int'(fl_valid && fl_ready), int'(in_valid && in_ready));
      if (in_ready && !(eng_busy && eng_op == 2))
        chk(0, "R4 in_ready outside program", 1, 0);
      if (fl_valid && fl_ready) begin
        chk(fl_data == src_idx[7:0], "R4 byte order", int'(fl_data), src_idx % 256);
        src_idx++; got++;
        chk(got <= eng_len, "R4 byte count", got, eng_len);
      end
    end
  end

  task automatic issue(int addr, int len, int seed);
    int a = addr, r = len, c;
    n_chunks = 0;
    while (r > 0) begin
      c = PB - (a % PB);
      if (c > r) c = r;
      exp_a[n_chunks] = a; exp_l[n_chunks] = c; n_chunks++;
      a += c; r -= c;
    end
    ck = 0; ph = 0; poll_seed = seed;
    req_start = 1; req_addr = AW'(addr); req_len = LW'(len);
    @(negedge clk);
    req_start = 0;
  endtask

  task automatic wait_done(int len, bit poke, bit b2b);
    bit seen = 0;
    for (int t = 0; t < 3000; t++) begin
      #1;
      if (done) begin seen = 1; if (len == 0) chk(t == 0, "R6 done latency", t, 0); break; end
      if (poke && t == 3) begin req_start = 1; req_addr = 16'h0ABC; req_len = 8'd3; end
      else req_start = 0;
      @(negedge clk);
    end
    req_start = 0;
    chk(seen, "R5 done seen", int'(seen), 1);
    chk(!busy, "R5 busy low with done", int'(busy), 0);
    chk(cache_inval == (len != 0), "R5 R6 invalidate", int'(cache_inval), int'(len != 0));
    chk(ck == n_chunks, poke ? "R7 chunks completed" : "R2 chunks completed", ck, n_chunks);
    if (!b2b) begin
      @(negedge clk); #1;
      chk(!done && !cache_inval, "R5 one-cycle pulse", int'(done), 0);
    end
  endtask

  initial begin
    rst_n = 0; req_start = 0; req_addr = 0; req_len = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !done && !cache_inval && !cmd_start && !fl_valid && !in_ready,
        "R1 reset state", int'(busy), 0);
    rst_n = 1;
    @(negedge clk);
    // back-to-back in done cycle
    issue(16'h0023, 20, 1); wait_done(20, 0, 1);
    issue(16'h0040, 0, 0);  wait_done(0, 0, 1);
    issue(16'h0105, 33, 2); wait_done(33, 0, 0);
    chk(1, "R8 back-to-back accepted", 1, 1);
    // ignored request while busy
    @(negedge clk);
    issue(16'h0207, 25, 0); wait_done(25, 1, 0);
    // sweep offsets and lengths
    for (int off = 0; off < PB; off++) begin
      for (int len = 0; len <= 40; len++) begin
        @(negedge clk);
        issue(((off * 7 + len) % 200) * PB + off, len, off + len);
        wait_done(len, (len % 7) == 3, 0);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule